// File: doc/BRIEF.md
# Debug Serial Command Responder

This block is the command engine on the target side of a full-duplex serial debug port. The serial shifter outside it turns each 17-bit transfer into one parallel word: the 16 bits the host sent arrive on `frm_rx`, and a one-cycle strobe marks the end of the transfer. In that same transfer the engine returns `frm_tx`, a 17-bit frame. When bit 16 is 0, the frame carries data in bits 15:0. When bit 16 is 1, the frame is a status code.

Each response lags its command by one frame and overlaps the next command. A memory read runs over several frames. The first frame carries the opcode, with the read size in its two low bits. The next two frames carry the high and then the low half of a 32-bit address. While the address is collected and while the access is outstanding, the engine answers "not ready". After the frame with the low address half, the engine starts one access on a request/acknowledge bus. The engine then returns the fetched value over the next two frames, high half first. The host frame that travels with the low result half is taken as the next opcode. A failed access returns a single error status frame instead of the data. The host frame sent alongside that error frame is also decoded as an opcode.

Top module: `dbg_cmd_engine`

## Requirements
- R1: With `rst` high at a clock edge, the engine goes idle, expects an opcode and drops `mem_req`. The response for the first transfer after reset is "command complete": bit16 0, data 0xFFFF (`frm_tx` = 0x0FFFF).
- R2: Opcode 0x0000 is a no-operation. The transfer that follows it returns "command complete".
- R3: Two kinds of opcode are illegal: any value other than 0x0000 or {0xD1, 000000, size}, and a read whose size field is 11. An illegal opcode makes the next transfer return 0x1FFFF. That next host frame is decoded as a new opcode.
- R4: A read opcode is {0xD1, six zero bits, size}, with size 00 for byte, 01 for word and 10 for long. The engine returns "not ready" (0x10000) in the transfer that carries the high address half. It returns "not ready" again in the transfer that carries the low address half.
- R5: After the transfer with the low address half, `mem_req` is high for exactly one cycle. At that time `mem_addr` = {high half, low half} and `mem_size` equals the size field. A read issues exactly one request.
- R6: While the access is outstanding, every transfer returns "not ready". Host frames received in that period are ignored, and no further request is made.
- R7: Once `mem_ack` arrives with `mem_err` low, the next transfer returns bits 31:16 of the result as data. The transfer after that returns bits 15:0.
- R8: For a byte read, the result is `mem_rdata[7:0]` zero-extended to 32 bits. For a word read, the result is `mem_rdata[15:0]` zero-extended.
- R9: When `mem_ack` arrives with `mem_err` high, the next transfer returns the error status 0x10001. The host frame received in that transfer is decoded as an opcode.
- R10: The host frame received with the low result half is decoded as the next opcode, so reads can follow one another back to back.
- R11: `mem_ack` is ignored when no access is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| frm_valid | input | 1 | One-cycle strobe: a transfer has completed |
| frm_rx | input | 16 | Word the host sent in that transfer |
| frm_tx | output | 17 | Response frame for the current transfer (bit 16 = status flag) |
| mem_req | output | 1 | One-cycle read request strobe |
| mem_addr | output | 32 | Read address |
| mem_size | output | 2 | Read size: 00 byte, 01 word, 10 long |
| mem_ack | input | 1 | Read completed |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_err | input | 1 | Read failed, valid with `mem_ack` |

## Verification
The hardest situation to reach is a set of host frames landing during an outstanding access. They must be answered "not ready", ignored, and must not cause a second request. The memory model in the bench holds off its acknowledge for ten cycles after the request. During that window the driver pushes three junk frames, and the model counts every request. A second hard case is the overlap at the end of a read, where the low result half travels with the next opcode. The stimulus chains byte, word, long and failing reads back to back so that each one's opcode rides in the previous read's last frame.

// File: rtl/dbg_cmd_engine.sv
module dbg_cmd_engine #(
  parameter int          WW      = 16,
  parameter logic [7:0]  RD_CODE = 8'hD1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frm_valid,
  input  logic [WW-1:0]   frm_rx,
  output logic [WW:0]     frm_tx,
  output logic            mem_req,
  output logic [2*WW-1:0] mem_addr,
  output logic [1:0]      mem_size,
  input  logic            mem_ack,
  input  logic [2*WW-1:0] mem_rdata,
  input  logic            mem_err
);
  localparam int AW = 2 * WW;
  localparam logic [WW:0] R_NRDY = {1'b1, {WW{1'b0}}};
  localparam logic [WW:0] R_BERR = {1'b1, {(WW-1){1'b0}}, 1'b1};
  localparam logic [WW:0] R_ILL  = {1'b1, {WW{1'b1}}};
  localparam logic [WW:0] R_CMPL = {1'b0, {WW{1'b1}}};

  typedef enum logic [2:0] {S_OP, S_AHI, S_ALO, S_WAIT, S_RHI, S_RLO} st_t;
  st_t st;

  logic [WW:0]   rsp;
  logic [WW-1:0] res_lo;
  logic [AW-1:0] ext;
  logic          waiting;

  wire op_nop = (frm_rx == '0);
  wire op_rd  = (frm_rx[WW-1:WW-8] == RD_CODE) && (frm_rx[WW-9:2] == '0) &&
                (frm_rx[1:0] != 2'b11);

  assign frm_tx  = rsp;
  assign waiting = (st == S_WAIT);

  always_comb begin
    case (mem_size)
      2'b00:   ext = {{(AW-8){1'b0}}, mem_rdata[7:0]};
      2'b01:   ext = {{(AW-WW){1'b0}}, mem_rdata[WW-1:0]};
      default: ext = mem_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_OP;
      rsp      <= R_CMPL;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_size <= 2'b00;
      res_lo   <= '0;
    end else begin
      mem_req <= 1'b0;
      if (st == S_WAIT) begin
        if (mem_ack) begin
          if (mem_err) begin
            rsp <= R_BERR;
            st  <= S_OP;
          end else begin
            rsp    <= {1'b0, ext[AW-1:WW]};
            res_lo <= ext[WW-1:0];
            st     <= S_RHI;
          end
        end
      end else if (frm_valid) begin
        case (st)
          S_AHI: begin
            mem_addr[AW-1:WW] <= frm_rx;
            rsp <= R_NRDY;
            st  <= S_ALO;
          end
          S_ALO: begin
            mem_addr[WW-1:0] <= frm_rx;
            mem_req <= 1'b1;
            rsp <= R_NRDY;
            st  <= S_WAIT;
          end
          S_RHI: begin
            rsp <= {1'b0, res_lo};
            st  <= S_RLO;
          end
          default: begin
            if (op_rd) begin
              mem_size <= frm_rx[1:0];
              rsp <= R_NRDY;
              st  <= S_AHI;
            end else begin
              rsp <= op_nop ? R_CMPL : R_ILL;
              st  <= S_OP;
            end
          end
        endcase
      end
    end
  end
endmodule

module dbg_cmd_engine_chk #(
  parameter int WW = 16
) (
  input logic        clk,
  input logic        rst,
  input logic [WW:0] frm_tx,
  input logic        mem_req,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        waiting
);
  localparam logic [WW:0] C_NRDY = {1'b1, {WW{1'b0}}};
  localparam logic [WW:0] C_BERR = {1'b1, {(WW-1){1'b0}}, 1'b1};
  localparam logic [WW:0] C_CMPL = {1'b0, {WW{1'b1}}};

  AST_RST_IDLE: assert property (@(posedge clk) rst |=> (frm_tx == C_CMPL && !mem_req)); // R1
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R5
  AST_REQ_IN_WAIT: assert property (@(posedge clk) disable iff (rst) mem_req |-> waiting); // R5
  AST_WAIT_NRDY: assert property (@(posedge clk) disable iff (rst) waiting |-> frm_tx == C_NRDY); // R6
  AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst) (waiting && !mem_req) |=> !mem_req); // R6
  AST_DATA_AFTER_ACK: assert property (@(posedge clk) disable iff (rst) (waiting && mem_ack && !mem_err) |=> !frm_tx[WW]); // R7
  AST_ERR_STATUS: assert property (@(posedge clk) disable iff (rst) (waiting && mem_ack && mem_err) |=> (frm_tx == C_BERR && !waiting)); // R9
endmodule

bind dbg_cmd_engine dbg_cmd_engine_chk #(.WW(WW)) u_chk (
  .clk(clk), .rst(rst), .frm_tx(frm_tx), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_err(mem_err), .waiting(waiting)
);

// File: tb/tb_dbg_cmd_engine.sv
`timescale 1ns/1ps
module tb_dbg_cmd_engine;
  localparam logic [16:0] NRDY = 17'h10000;
  localparam logic [16:0] CMPL = 17'h0FFFF;
  localparam logic [16:0] ILL  = 17'h1FFFF;
  localparam logic [16:0] BERR = 17'h10001;
  localparam logic [15:0] NOP  = 16'h0000;
  localparam logic [15:0] RD_B = 16'hD100;
  localparam logic [15:0] RD_W = 16'hD101;
  localparam logic [15:0] RD_L = 16'hD102;
  localparam logic [15:0] RD_X = 16'hD103;

  logic clk = 0, rst = 1, frm_valid = 0;
  logic [15:0] frm_rx = '0;
  logic [16:0] frm_tx;
  logic mem_req, mem_err = 0, model_ack = 0, stray_ack = 0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [1:0] mem_size;
  wire mem_ack = model_ack | stray_ack;

  int checks = 0, errors = 0, reqs = 0;
  bit done = 0, acked = 0;
  logic [31:0] exp_addr, m_data;
  logic [1:0]  exp_size;
  logic        m_err;
  int          m_delay = 2;
  logic [16:0] exq[$];
  string       tgq[$];

  always #2.5 clk = ~clk;

  dbg_cmd_engine dut (
    .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_rx(frm_rx), .frm_tx(frm_tx),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input logic [16:0] e, input string tag);
    @(negedge clk);
    frm_rx = w; frm_valid = 1;
    exq.push_back(e); tgq.push_back(tag);
    @(negedge clk);
    frm_valid = 0;
  endtask

  // monitor: pops expected responses as transfers occur
  always @(negedge clk) begin
    #1;
    if (frm_valid) begin
      if (exq.size() == 0) chk(0, "monitor-underflow", {15'd0, frm_tx}, 32'd0);
      else begin
        logic [16:0] e;
        string t;
        e = exq.pop_front(); t = tgq.pop_front();
        chk(frm_tx === e, t, {15'd0, frm_tx}, {15'd0, e});
      end
    end
  end

  // memory model
  always begin
    @(negedge clk);
    if (mem_req === 1'b1) begin
      reqs++;
      chk(mem_addr === exp_addr, "R5 addr", mem_addr, exp_addr);
      chk(mem_size === exp_size, "R5 size", {30'd0, mem_size}, {30'd0, exp_size});
      for (int i = 0; i < m_delay; i++) begin
        @(negedge clk);
        if (i == 0) chk(mem_req === 1'b0, "R5 single-cycle req", {31'd0, mem_req}, 32'd0);
      end
      mem_rdata = m_data; mem_err = m_err; model_ack = 1;
      @(negedge clk);
      model_ack = 0; mem_err = 0; mem_rdata = 32'h5A5A_A5A5;
      acked = 1;
    end
  end

  task automatic start_read(input logic [15:0] op, input logic [16:0] prev, input logic [31:0] a,
                            input logic [31:0] d, input logic e, input int dly);
    exp_addr = a; exp_size = op[1:0]; m_data = d; m_err = e; m_delay = dly; acked = 0;
    xfer(op, prev, "R10 opcode frame");
    xfer(a[31:16], NRDY, "R4 high address");
    xfer(a[15:0], NRDY, "R4 low address");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk(frm_tx === CMPL, "R1 reset response", {15'd0, frm_tx}, {15'd0, CMPL});
    chk(mem_req === 1'b0, "R1 reset req", {31'd0, mem_req}, 32'd0);

    xfer(NOP, CMPL, "R1 first response");
    xfer(NOP, CMPL, "R2 nop complete");
    xfer(16'h1234, CMPL, "R2 after nop");
    xfer(RD_X, ILL, "R3 unknown opcode");
    xfer(NOP, ILL, "R3 size 11 illegal");
    xfer(NOP, CMPL, "R3 redecoded as opcode");

    // long read, frames during the access
    start_read(RD_L, CMPL, 32'h0012_3456, 32'hCAFE_8001, 0, 10);
    for (int k = 0; k < 3; k++) xfer(16'hAAAA, NRDY, "R6 busy frame");
    wait (acked); @(negedge clk);
    chk(reqs == 1, "R6 one request", reqs, 1);
    xfer(16'h5555, 17'h0CAFE, "R7 high result");
    // byte read overlapping the last result frame
    start_read(RD_B, 17'h08001, 32'h0000_0041, 32'hFFFF_FF9C, 0, 2);
    wait (acked); @(negedge clk);
    xfer(16'h7777, 17'h00000, "R8 byte high zero");
    start_read(RD_W, 17'h0009C, 32'h0000_8002, 32'h1234_BEEF, 0, 3);
    wait (acked); @(negedge clk);
    xfer(16'h0F0F, 17'h00000, "R8 word high zero");
    // failing read
    start_read(RD_L, 17'h0BEEF, 32'h0000_0003, 32'h1111_2222, 1, 4);
    wait (acked); @(negedge clk);
    xfer(NOP, BERR, "R9 error status");
    xfer(NOP, CMPL, "R9 redecoded as opcode");

    // stray acknowledge while idle
    @(negedge clk); stray_ack = 1; mem_rdata = 32'h9999_9999;
    @(negedge clk); stray_ack = 0;
    xfer(NOP, CMPL, "R11 stray ack ignored");
    chk(reqs == 4, "R11 request count", reqs, 4);

    // reset in the middle of address collection
    exp_addr = 32'h0; exp_size = 2'b10;
    xfer(RD_L, CMPL, "R10 opcode frame");
    xfer(16'h00AB, NRDY, "R4 high address");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    #1;
    chk(frm_tx === CMPL, "R1 mid-command reset", {15'd0, frm_tx}, {15'd0, CMPL});
    xfer(NOP, CMPL, "R1 idle after reset");
    repeat (4) @(negedge clk);
    chk(reqs == 4, "R5 no request after reset", reqs, 4);
    chk(exq.size() == 0, "R7 queue drained", exq.size(), 0);
    finish_run();
  end
endmodule